// File: doc/BRIEF.md
# Quarter-Period Zero-Crossing Solver

This block turns one sample of a square-wave carrier's phase into edge timing for that sample period. Each clock it may accept a start phase and the phase advance that the carrier gains over the period. The phase is assumed to grow linearly across the period, and the period is cut into four equal quarters. For each quarter the block decides whether the square wave changes level inside it. If it does, the block reports the fine time step at which the change happens, so that a downstream delay scheduler can place the edge.

A quarter's span of phase is always below half a turn, so it holds at most one level boundary. Each quarter therefore needs only two things: a test that compares the level at its start with the level at its end, and a pipelined bisection that finds the step where the level flips. The four quarters are solved side by side in one pipeline, and their results leave together with a valid flag.

Top module: `zc_quarter_solver`

## Requirements
- R1: Phases are unsigned and a full turn (2π) equals 2^PHASE_W. `in_phase` is PHASE_W bits wide. `in_adv` is PHASE_W+1 bits wide and covers the range [0, 4π). Every value in that range is handled.
- R2: With K = 2^PHASE_W, the phase at fine step m (0..K) of the period is in_phase + m·in_adv/K, taken modulo 2π and computed exactly. Quarter i spans steps i·K/4 to (i+1)·K/4.
- R3: The carrier level is high when the wrapped phase lies in [0, π/2) or [3π/2, 2π), and low when it lies in [π/2, 3π/2). `out_en[i]` is 1 exactly when the level at step (i+1)·K/4 differs from the level at step i·K/4.
- R4: For an enabled quarter, its index t (PHASE_W-2 bits) is the largest offset in 0..K/4-1 whose level still equals the level at the quarter's start. The edge therefore lies between offsets t and t+1.
- R5: When a quarter is not enabled, its index reads 0. A period with no crossing, such as one with zero advance, enables no quarter.
- R6: Results appear with `out_valid` exactly PHASE_W-1 clocks after the input edge that captured the sample. Samples may arrive on back-to-back cycles, and `out_valid` is low whenever no sample is due.
- R7: Reset is synchronous and active-high. It clears `out_valid`, `out_en` and `out_idx` to 0.
- R8: Quarter i reports on bit i of `out_en` and on bits [i·(PHASE_W-2) +: PHASE_W-2] of `out_idx`, with quarter 0 being the earliest in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_phase | input | PHASE_W | Phase at the start of the period |
| in_adv | input | PHASE_W+1 | Phase advance over the period |
| out_valid | output | 1 | Results present this cycle |
| out_en | output | 4 | Per-quarter crossing flag |
| out_idx | output | 4·(PHASE_W-2) | Per-quarter fine step index |

## Verification
A new sample entering the setup stage and an older sample leaving the last bisection stage happen in the same cycle whenever inputs arrive back to back. The bench drives long unbroken runs of random samples, interleaved with idle gaps, so that entry and exit overlap. Each result is matched in order against a reference that walks every fine step of each quarter, and the bench also checks that the result arrives exactly the fixed number of clocks after its sample.

// File: rtl/zcs_pkg.sv
package zcs_pkg;
  localparam int NUM_Q = 4;

  // Square-wave level from the top two bits of a wrapped phase: low in [pi/2, 3pi/2)
  function automatic logic level_of(input logic [1:0] top2);
    return top2[1] ^ top2[0];
  endfunction
endpackage

// File: rtl/zc_quarter_setup.sv
module zc_quarter_setup #(
  parameter int PHASE_W = 10,
  parameter int QIDX    = 0,
  localparam int ADV_W  = PHASE_W + 1,
  localparam int ACC_W  = 2 * PHASE_W,
  localparam int KB     = PHASE_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PHASE_W-1:0] in_phase,
  input  logic [ADV_W-1:0] in_adv,
  output logic             out_en,
  output logic             out_lvl,
  output logic [ACC_W-1:0] out_acc,
  output logic [ADV_W-1:0] out_adv
);
  import zcs_pkg::*;

  logic [ACC_W-1:0] quarter_step;
  logic [ACC_W-1:0] acc_start;
  logic [ACC_W-1:0] acc_end;
  logic             lvl_start;
  logic             lvl_end;

  always_comb begin
    quarter_step = ACC_W'(in_adv) << KB;
    acc_start    = {in_phase, {PHASE_W{1'b0}}} + quarter_step * ACC_W'(QIDX);
    acc_end      = acc_start + quarter_step;
    lvl_start    = level_of(acc_start[ACC_W-1 -: 2]);
    lvl_end      = level_of(acc_end[ACC_W-1 -: 2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_en  <= 1'b0;
      out_lvl <= 1'b0;
      out_acc <= '0;
      out_adv <= '0;
    end else begin
      out_en  <= lvl_start != lvl_end;
      out_lvl <= lvl_start;
      out_acc <= acc_start;
      out_adv <= in_adv;
    end
  end

  // The registered start phase must carry the registered start level
  assert_start_level_R3: assert property (@(posedge clk) disable iff (rst)
    out_lvl == level_of(out_acc[ACC_W-1 -: 2]));
endmodule

// File: rtl/zc_bisect_step.sv
module zc_bisect_step #(
  parameter int ACC_W = 20,
  parameter int ADV_W = 11,
  parameter int KB    = 8,
  parameter int BIT   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_en,
  input  logic             in_lvl,
  input  logic [ACC_W-1:0] in_acc,
  input  logic [ADV_W-1:0] in_adv,
  input  logic [KB-1:0]    in_t,
  output logic             out_en,
  output logic             out_lvl,
  output logic [ACC_W-1:0] out_acc,
  output logic [ADV_W-1:0] out_adv,
  output logic [KB-1:0]    out_t
);
  import zcs_pkg::*;

  logic [ACC_W-1:0] try_acc;
  logic             try_same;

  always_comb begin
    try_acc  = in_acc + (ACC_W'(in_adv) << BIT);
    try_same = level_of(try_acc[ACC_W-1 -: 2]) == in_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_en  <= 1'b0;
      out_lvl <= 1'b0;
      out_acc <= '0;
      out_adv <= '0;
      out_t   <= '0;
    end else begin
      out_en  <= in_en;
      out_lvl <= in_lvl;
      out_adv <= in_adv;
      if (in_en && try_same) begin
        out_acc <= try_acc;
        out_t   <= in_t | (KB'(1) << BIT);
      end else begin
        out_acc <= in_acc;
        out_t   <= in_t;
      end
    end
  end

  // The kept point never crosses to the other side of the boundary
  assert_keep_side_R4: assert property (@(posedge clk) disable iff (rst)
    out_en |-> (level_of(out_acc[ACC_W-1 -: 2]) == out_lvl));
  // The index only gains bits as the search narrows
  assert_t_monotone_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_t >= $past(in_t)));
  // A quarter without a crossing keeps a zero index
  assert_idle_index_R5: assert property (@(posedge clk) disable iff (rst)
    (!in_en && in_t == '0) |=> (out_t == '0));
endmodule

// File: rtl/zc_quarter_solver.sv
module zc_quarter_solver #(
  parameter int PHASE_W = 10,
  localparam int ADV_W  = PHASE_W + 1,
  localparam int ACC_W  = 2 * PHASE_W,
  localparam int KB     = PHASE_W - 2,
  localparam int LAT    = KB + 1,
  localparam int NQ     = zcs_pkg::NUM_Q
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [PHASE_W-1:0] in_phase,
  input  logic [ADV_W-1:0]   in_adv,
  output logic               out_valid,
  output logic [NQ-1:0]      out_en,
  output logic [NQ*KB-1:0]   out_idx
);
  logic             en_c  [NQ][KB+1];
  logic             lvl_c [NQ][KB+1];
  logic [ACC_W-1:0] acc_c [NQ][KB+1];
  logic [ADV_W-1:0] adv_c [NQ][KB+1];
  logic [KB-1:0]    t_c   [NQ][KB+1];
  logic [LAT-1:0]   vld_sr;

  for (genvar q = 0; q < NQ; q++) begin : g_quarter
    zc_quarter_setup #(.PHASE_W(PHASE_W), .QIDX(q)) i_setup (
      .clk(clk), .rst(rst), .in_phase(in_phase), .in_adv(in_adv),
      .out_en(en_c[q][0]), .out_lvl(lvl_c[q][0]),
      .out_acc(acc_c[q][0]), .out_adv(adv_c[q][0]));
    assign t_c[q][0] = '0;

    for (genvar s = 0; s < KB; s++) begin : g_step
      zc_bisect_step #(.ACC_W(ACC_W), .ADV_W(ADV_W), .KB(KB), .BIT(KB-1-s)) i_step (
        .clk(clk), .rst(rst),
        .in_en(en_c[q][s]), .in_lvl(lvl_c[q][s]), .in_acc(acc_c[q][s]),
        .in_adv(adv_c[q][s]), .in_t(t_c[q][s]),
        .out_en(en_c[q][s+1]), .out_lvl(lvl_c[q][s+1]), .out_acc(acc_c[q][s+1]),
        .out_adv(adv_c[q][s+1]), .out_t(t_c[q][s+1]));
    end

    assign out_en[q]           = en_c[q][KB];
    assign out_idx[q*KB +: KB] = t_c[q][KB];

    logic unused_tail;
    assign unused_tail = ^{lvl_c[q][KB], acc_c[q][KB], adv_c[q][KB]};

    assert_off_zero_R5: assert property (@(posedge clk) disable iff (rst)
      !out_en[q] |-> (out_idx[q*KB +: KB] == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) vld_sr <= '0;
    else     vld_sr <= {vld_sr[LAT-2:0], in_valid};
  end
  assign out_valid = vld_sr[LAT-1];

  // Checker: results may only leave for samples that actually entered
  localparam int CW = $clog2(LAT + 2) + 1;
  logic [CW-1:0] in_flight;
  always_ff @(posedge clk) begin
    if (rst) in_flight <= '0;
    else     in_flight <= in_flight + CW'(in_valid) - CW'(out_valid);
  end
  assert_valid_sourced_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (in_flight != '0));
  assert_flight_bound_R6: assert property (@(posedge clk) disable iff (rst)
    in_flight <= CW'(LAT));
endmodule

// File: tb/test_zc_quarter_solver.sv
module test_zc_quarter_solver;
  localparam int PW  = 10;
  localparam int KB  = PW - 2;
  localparam int Q   = 1 << KB;
  localparam int LAT = PW - 1;
  localparam int MAXS = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [PW-1:0]     in_phase = '0;
  logic [PW:0]       in_adv = '0;
  logic              out_valid;
  logic [3:0]        out_en;
  logic [4*KB-1:0]   out_idx;

  zc_quarter_solver #(.PHASE_W(PW)) i_zc_quarter_solver (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase), .in_adv(in_adv),
    .out_valid(out_valid), .out_en(out_en), .out_idx(out_idx));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, nsent = 0, nrecv = 0;
  bit done = 0;
  logic [3:0]    exp_en  [MAXS];
  logic [KB-1:0] exp_idx [MAXS][4];
  int            exp_cyc [MAXS];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit lvl_at(input int ph, input int adv, input int m);
    longint acc;
    acc = ((longint'(ph) << PW) + longint'(m) * longint'(adv)) & ((longint'(1) << (2*PW)) - 1);
    return acc[2*PW-1] ^ acc[2*PW-2];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int ph, input int adv);
    bit l0;
    in_valid = 1'b1;
    in_phase = PW'(ph);
    in_adv   = (PW+1)'(adv);
    for (int q = 0; q < 4; q++) begin
      l0 = lvl_at(ph, adv, q*Q);
      exp_en[nsent][q] = (lvl_at(ph, adv, (q+1)*Q) != l0);
      exp_idx[nsent][q] = '0;
      if (exp_en[nsent][q])
        for (int j = 0; j < Q; j++)
          if (lvl_at(ph, adv, q*Q + j) == l0) exp_idx[nsent][q] = KB'(j);
    end
    exp_cyc[nsent] = cyc;
    nsent++;
  endtask

  // Monitor: outputs change at posedge, sampled at negedge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (nrecv >= nsent) check(1'b0, "R6 unexpected valid", nrecv, nsent);
        else begin
          check(cyc - exp_cyc[nrecv] == LAT, "R6 latency", cyc - exp_cyc[nrecv], LAT);
          for (int q = 0; q < 4; q++) begin
            // R3 enable per quarter, R8 bit order
            check(out_en[q] == exp_en[nrecv][q], "R3/R8 enable", out_en[q], exp_en[nrecv][q]);
            // R4 index of enabled quarter, R5 zero when disabled
            check(out_idx[q*KB +: KB] == exp_idx[nrecv][q],
                  exp_en[nrecv][q] ? "R4 index" : "R5 idle index",
                  out_idx[q*KB +: KB], exp_idx[nrecv][q]);
          end
          nrecv++;
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 60000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", nrecv, nsent);
      finish_run();
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R7: reset state
    check(out_valid == 1'b0, "R7 valid", out_valid, 0);
    check(out_en == '0, "R7 enable", out_en, 0);
    check(out_idx == '0, "R7 index", out_idx, 0);
    rst = 1'b0;
    @(negedge clk);
    // Directed corners
    send(100, 0);                 // R5: no advance, no crossing
    @(negedge clk); send(255, 1); // R2/R4: crossing at the very last step of quarter 3
    @(negedge clk); send(256, 0); // on a boundary, still
    @(negedge clk); send(0, 2047);// R1: largest advance
    @(negedge clk); send(1023, 2047);
    @(negedge clk); send(768, 512);
    @(negedge clk); send(0, 1024);
    @(negedge clk); in_valid = 1'b0;
    repeat (12) @(negedge clk);
    // R6: random bursts back to back with idle gaps
    for (int b = 0; b < 30; b++) begin
      int len;
      len = 1 + int'($urandom % 12);
      for (int s = 0; s < len; s++) begin
        int adv;
        adv = ($urandom % 3 == 0) ? int'($urandom % 64) : int'($urandom % 2048);
        send(int'($urandom % 1024), adv);
        @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (int'($urandom % 4)) @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (LAT + 4) @(negedge clk);
    check(nrecv == nsent, "R6 all results", nrecv, nsent);
    finish_run();
  end
endmodule